// File: doc/BRIEF.md
# Nonvolatile Byte Array Programming Controller

This block models the programming side of a small on-chip nonvolatile byte store: a main array and a small user region, both held as internal register files. A synchronous command port accepts byte writes, byte reads, a chip erase, a signature read, lock programming, fuse programming and a status read. Write and erase cycles are self-timed by one shared down-counter whose length comes from a parameter per operation. While a cycle runs, the active-low `busy_no` output is held low.

Progress can also be followed by data polling. While a write is pending, a read of the address being written returns the pending byte with bit 7 inverted. During an erase every array read returns 00h. Two lock bits hide the array content from reads but leave the status byte readable. A serial-enable fuse gates all commands issued without the privileged mode flag. Any mode may clear that fuse, but only the privileged mode may set it. A user-keep fuse decides whether chip erase also wipes the user region.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: A write (op 1) accepted at a clock edge drives `busy_no` low for exactly WR_CYCLES cycles, starting right after that edge. The byte becomes readable once `busy_no` returns high.
- R2: While a write is pending, a read (op 2) whose address and `usr_sel_i` match the pending write returns the pending byte XOR 80h. A read of any other address returns the stored content.
- R3: A write, erase (op 3), lock (op 5) or fuse (op 6) command issued while busy, or any command with op 0, has no effect and raises `err_o` for exactly one cycle. Reads remain accepted while busy.
- R4: An erase holds `busy_no` low for ER_CYCLES cycles. When it completes, every main-array byte reads FFh and both lock bits are cleared.
- R5: A read (op 2) issued while an erase is running returns 00h.
- R6: Erase clears the user region (read with `usr_sel_i`=1) to FFh only if the user-keep fuse (status bit 3) is 0. If that fuse is 1, the user bytes are kept.
- R7: A lock command ORs `wdata_i[1:0]` into the lock bits. While either lock bit is 1, array reads return 00h, and the status read still shows the lock bits in status bits 1:0.
- R8: The serial-enable fuse (status bit 2) resets to 1. A fuse command with `wdata_i[2]`=0 clears it in either mode. `wdata_i[2]`=1 sets it only when `priv_mode_i`=1. `wdata_i[3]` writes the user-keep fuse, which resets to 1.
- R9: While the serial-enable fuse is 0, every command with `priv_mode_i`=0 is ignored: `rvalid_o` stays low, no state changes, and `err_o` pulses.
- R10: A signature read (op 4) returns 1Eh at address 30h, 73h at address 31h and 00h at any other address.
- R11: After reset, `busy_no`=1, `err_o`=0 and `rvalid_o`=0, and a status read (op 7) returns 0Ch.
- R12: For an accepted read, signature read or status read, `rdata_o` is valid and `rvalid_o` is high for exactly the one cycle that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe for one cycle |
| cmd_op_i | input | 3 | Operation code |
| priv_mode_i | input | 1 | 1 = privileged (parallel) mode, 0 = serial mode |
| usr_sel_i | input | 1 | Selects the user region for read and write |
| addr_i | input | AW | Byte address |
| wdata_i | input | 8 | Write data, lock mask or fuse values |
| rdata_o | output | 8 | Read result |
| rvalid_o | output | 1 | Read result valid |
| busy_no | output | 1 | Low while a write or erase cycle runs |
| err_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
The assertions check, on every cycle, the properties that hold from one cycle to the next:
- a busy command raises the error pulse;
- a started write pulls `busy_no` low;
- a read during erase yields zero;
- the timer never restarts while busy;
- a set lock bit holds until an erase completes;
- a cleared serial-enable fuse cannot be set from serial mode.

Only the bench's scenarios can show the rest:
- the exact busy durations;
- the polled value and the true byte after completion;
- the effect of the user-keep fuse on the user region;
- the signature values;
- the fact that rejected serial writes leave the array unchanged.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_ERASE = 3'd3,
    OP_SIG   = 3'd4,
    OP_LOCK  = 3'd5,
    OP_FUSE  = 3'd6,
    OP_STAT  = 3'd7
  } op_e;

  localparam logic [7:0] SIG_LO_ADDR = 8'h30;
  localparam logic [7:0] SIG_HI_ADDR = 8'h31;
  localparam logic [7:0] SIG_LO_VAL  = 8'h1E;
  localparam logic [7:0] SIG_HI_VAL  = 8'h73;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= len_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_count_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/nvm_byte_store.sv
module nvm_byte_store #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          erase_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  import nvm_prog_pkg::*;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nvm_guard_bits.sv
module nvm_guard_bits (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_wr_i,
  input  logic       fuse_wr_i,
  input  logic       priv_i,
  input  logic       clr_lock_i,
  input  logic [7:0] wdata_i,
  output logic [1:0] lock_o,
  output logic       ser_en_o,
  output logic       usr_keep_o
);
  logic [1:0] lock_q;
  logic       ser_en_q, usr_keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 2'b00;
      ser_en_q   <= 1'b1;
      usr_keep_q <= 1'b1;
    end else begin
      if (clr_lock_i)     lock_q <= 2'b00;
      else if (lock_wr_i) lock_q <= lock_q | wdata_i[1:0];
      if (fuse_wr_i) begin
        // clearing is free, setting needs privileged mode
        ser_en_q   <= wdata_i[2] ? (ser_en_q | priv_i) : 1'b0;
        usr_keep_q <= wdata_i[3];
      end
    end
  end

  assign lock_o     = lock_q;
  assign ser_en_o   = ser_en_q;
  assign usr_keep_o = usr_keep_q;

  p_ser_no_serial_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_en_q && !priv_i) |=> !ser_en_q);
  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|lock_q) && !clr_lock_i) |=> (|lock_q));
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl #(
  parameter int DEPTH     = 256,
  parameter int USR_DEPTH = 32,
  parameter int WR_CYCLES = 40,
  parameter int ER_CYCLES = 2000,
  localparam int AW   = $clog2(DEPTH),
  localparam int UAW  = $clog2(USR_DEPTH),
  localparam int MAXC = (WR_CYCLES > ER_CYCLES) ? WR_CYCLES : ER_CYCLES,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic          priv_mode_i,
  input  logic          usr_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          rvalid_o,
  output logic          busy_no,
  output logic          err_o
);
  import nvm_prog_pkg::*;

  op_e        op;
  logic       is_prog, is_rd, allowed, acc;
  logic       start_wr, start_er, busy, done;
  logic       erasing_q, pend_usr_q;
  logic [AW-1:0] pend_addr_q;
  logic [7:0] pend_data_q;
  logic [1:0] lock;
  logic       ser_en, usr_keep;
  logic [7:0] main_rd, usr_rd, rd_val, stat;
  logic [7:0] rdata_q;
  logic       rvalid_q, err_q;

  assign op = op_e'(cmd_op_i);

  always_comb begin
    is_prog  = (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_LOCK) || (op == OP_FUSE);
    is_rd    = (op == OP_READ) || (op == OP_SIG) || (op == OP_STAT);
    allowed  = (priv_mode_i || ser_en) && (is_rd || (is_prog && !busy));
    acc      = cmd_valid_i && allowed;
    start_wr = acc && (op == OP_WRITE);
    start_er = acc && (op == OP_ERASE);
  end

  nvm_cycle_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wr || start_er),
    .len_i   (start_er ? CW'(ER_CYCLES - 1) : CW'(WR_CYCLES - 1)),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erasing_q   <= 1'b0;
      pend_usr_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      if (start_er)  erasing_q <= 1'b1;
      else if (done) erasing_q <= 1'b0;
      if (start_wr) begin
        pend_usr_q  <= usr_sel_i;
        pend_addr_q <= addr_i;
        pend_data_q <= wdata_i;
      end
    end
  end

  nvm_byte_store #(.DEPTH(DEPTH)) u_main (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done && !erasing_q && !pend_usr_q),
    .erase_i (done && erasing_q),
    .waddr_i (pend_addr_q),
    .wdata_i (pend_data_q),
    .raddr_i (addr_i),
    .rdata_o (main_rd)
  );

  nvm_byte_store #(.DEPTH(USR_DEPTH)) u_user (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done && !erasing_q && pend_usr_q),
    .erase_i (done && erasing_q && !usr_keep),
    .waddr_i (pend_addr_q[UAW-1:0]),
    .wdata_i (pend_data_q),
    .raddr_i (addr_i[UAW-1:0]),
    .rdata_o (usr_rd)
  );

  nvm_guard_bits u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_wr_i  (acc && (op == OP_LOCK)),
    .fuse_wr_i  (acc && (op == OP_FUSE)),
    .priv_i     (priv_mode_i),
    .clr_lock_i (done && erasing_q),
    .wdata_i    (wdata_i),
    .lock_o     (lock),
    .ser_en_o   (ser_en),
    .usr_keep_o (usr_keep)
  );

  assign stat = {4'b0000, usr_keep, ser_en, lock};

  always_comb begin
    rd_val = 8'h00;
    unique case (op)
      OP_READ: begin
        if (erasing_q)
          rd_val = 8'h00;
        else if (busy && addr_i == pend_addr_q && usr_sel_i == pend_usr_q)
          rd_val = pend_data_q ^ 8'h80; // data polling
        else if (|lock)
          rd_val = 8'h00;
        else
          rd_val = usr_sel_i ? usr_rd : main_rd;
      end
      OP_SIG: begin
        if (8'(addr_i) == SIG_LO_ADDR)      rd_val = SIG_LO_VAL;
        else if (8'(addr_i) == SIG_HI_ADDR) rd_val = SIG_HI_VAL;
      end
      OP_STAT: rd_val = stat;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= acc && is_rd;
      err_q    <= cmd_valid_i && !allowed;
      if (acc && is_rd) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign busy_no  = !busy;
  assign err_o    = err_q;

  p_busy_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_no && (op == OP_WRITE || op == OP_ERASE)) |=> err_o);
  p_write_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> !busy_no);
  p_erase_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op == OP_READ && erasing_q) |=> (rvalid_o && rdata_o == 8'h00));
  p_rvalid_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && is_rd) |=> !rvalid_o);
endmodule

// File: tb/nvm_prog_ctrl_bench.sv
module nvm_prog_ctrl_bench;
  localparam int DEPTH = 256;
  localparam int USR_DEPTH = 16;
  localparam int WRC = 6;
  localparam int ERC = 12;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic priv = 1'b1;
  logic usr_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rvalid, busy_n, err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nvm_prog_ctrl #(.DEPTH(DEPTH), .USR_DEPTH(USR_DEPTH), .WR_CYCLES(WRC), .ER_CYCLES(ERC))
  u_nvm_prog_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .priv_mode_i(priv), .usr_sel_i(usr_sel), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .busy_no(busy_n), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int a, input logic [7:0] d,
                     input bit u, input bit p);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; addr = AW'(a); wdata = d; usr_sel = u; priv = p;
    @(negedge clk);
    cmd_valid = 1'b0; priv = 1'b1; usr_sel = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, input int a, input bit u, input bit p,
                    output logic [7:0] v);
    cmd(op, a, 8'h00, u, p);
    v = rdata;
  endtask

  task automatic wait_ready();
    while (!busy_n) @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!busy_n) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(busy_n == 1'b1, "R11 busy_no", busy_n, 1);
    check(err == 1'b0, "R11 err", err, 0);
    check(rvalid == 1'b0, "R11 rvalid", rvalid, 0);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h0C, "R11 status", v, 8'h0C);
  endtask

  task automatic t_write();
    int n;
    logic [7:0] v;
    cmd(3'd1, 5, 8'h3C, 0, 1);
    count_busy(n);
    check(n == WRC, "R1 busy length", n, WRC);
    check(rvalid == 1'b0, "R12 idle rvalid", rvalid, 0);
    rd(3'd2, 5, 0, 1, v);
    check(v == 8'h3C, "R1 committed byte", v, 8'h3C);
    check(rvalid == 1'b1, "R12 rvalid after read", rvalid, 1);
    @(negedge clk);
    check(rvalid == 1'b0, "R12 rvalid single cycle", rvalid, 0);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    cmd(3'd1, 7, 8'h5A, 0, 1);
    rd(3'd2, 7, 0, 1, v);
    check(v == 8'hDA, "R2 polled byte", v, 8'hDA);
    rd(3'd2, 8, 0, 1, v);
    check(v == 8'hFF, "R2 other address", v, 8'hFF);
    wait_ready();
    rd(3'd2, 7, 0, 1, v);
    check(v == 8'h5A, "R2 true after cycle", v, 8'h5A);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    cmd(3'd1, 9, 8'h11, 0, 1);
    cmd(3'd1, 10, 8'h22, 0, 1);
    check(err == 1'b1, "R3 err on busy write", err, 1);
    @(negedge clk);
    check(err == 1'b0, "R3 err one cycle", err, 0);
    rd(3'd2, 11, 0, 1, v);
    check(rvalid == 1'b1 && err == 1'b0, "R3 read while busy", {rvalid, err}, 2);
    wait_ready();
    rd(3'd2, 10, 0, 1, v);
    check(v == 8'hFF, "R3 ignored write", v, 8'hFF);
    rd(3'd2, 9, 0, 1, v);
    check(v == 8'h11, "R3 first write kept", v, 8'h11);
    cmd(3'd0, 0, 8'h00, 0, 1);
    check(err == 1'b1, "R3 err on op 0", err, 1);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    cmd(3'd1, 0, 8'hAB, 1, 1);
    wait_ready();
    cmd(3'd5, 0, 8'h02, 0, 1);
    rd(3'd2, 9, 0, 1, v);
    check(v == 8'h00, "R7 locked read", v, 8'h00);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h0E, "R7 status with lock", v, 8'h0E);
  endtask

  task automatic t_erase_keep();
    int n;
    logic [7:0] v;
    cmd(3'd3, 0, 8'h00, 0, 1);
    count_busy(n);
    check(n == ERC, "R4 erase length", n, ERC);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h0C, "R4 locks cleared", v, 8'h0C);
    rd(3'd2, 9, 0, 1, v);
    check(v == 8'hFF, "R4 main erased", v, 8'hFF);
    rd(3'd2, 5, 0, 1, v);
    check(v == 8'hFF, "R4 main erased 2", v, 8'hFF);
    rd(3'd2, 0, 1, 1, v);
    check(v == 8'hAB, "R6 user kept", v, 8'hAB);
  endtask

  task automatic t_erase_user();
    logic [7:0] v;
    cmd(3'd6, 0, 8'h04, 0, 1);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h04, "R8 user-keep fuse cleared", v, 8'h04);
    cmd(3'd1, 3, 8'h66, 0, 1);
    wait_ready();
    cmd(3'd3, 0, 8'h00, 0, 1);
    rd(3'd2, 3, 0, 1, v);
    check(v == 8'h00, "R5 read during erase", v, 8'h00);
    wait_ready();
    rd(3'd2, 0, 1, 1, v);
    check(v == 8'hFF, "R6 user erased", v, 8'hFF);
  endtask

  task automatic t_sig();
    logic [7:0] v;
    rd(3'd4, 8'h30, 0, 1, v);
    check(v == 8'h1E, "R10 signature 30h", v, 8'h1E);
    rd(3'd4, 8'h31, 0, 1, v);
    check(v == 8'h73, "R10 signature 31h", v, 8'h73);
    rd(3'd4, 8'h32, 0, 1, v);
    check(v == 8'h00, "R10 other offset", v, 8'h00);
  endtask

  task automatic t_serfuse();
    logic [7:0] v;
    rd(3'd2, 7, 0, 0, v);
    check(rvalid == 1'b1 && v == 8'hFF, "R9 serial read enabled", v, 8'hFF);
    cmd(3'd6, 0, 8'h00, 0, 0);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h00, "R8 serial clear", v, 8'h00);
    cmd(3'd2, 7, 8'h00, 0, 0);
    check(rvalid == 1'b0 && err == 1'b1, "R9 serial read blocked", {rvalid, err}, 1);
    cmd(3'd1, 1, 8'h42, 0, 0);
    check(err == 1'b1, "R9 serial write err", err, 1);
    wait_ready();
    rd(3'd2, 1, 0, 1, v);
    check(v == 8'hFF, "R9 serial write ignored", v, 8'hFF);
    cmd(3'd6, 0, 8'h04, 0, 0);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h00, "R8 serial set refused", v, 8'h00);
    cmd(3'd6, 0, 8'h04, 0, 1);
    rd(3'd7, 0, 0, 1, v);
    check(v == 8'h04, "R8 privileged set", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_poll();
    t_busy();
    t_lock();
    t_erase_keep();
    t_erase_user();
    t_sig();
    t_serfuse();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule